// File: doc/BRIEF.md
# Shifter Operand Generator

This block forms the second operand of an arithmetic/logic unit together with the carry that the shifting step produces. It works in one of two modes. In immediate mode an 8-bit constant is zero-extended to 32 bits and rotated right by twice a 4-bit rotate field. In register mode a 32-bit register value is shifted by one of four kinds of shift. The shift amount comes either from a 5-bit field or from the low byte of a second register, so amounts from 0 to 255 must be handled.

The incoming carry flag passes through unchanged whenever the operation moves no bits. The operand and the carry-out feed the ALU and the flag update logic in the same cycle. The block has no state and no clock. Instruction decode and register file access are handled elsewhere.

Top module: `shift_operand_unit`

## Requirements
- R1: With `imm_mode_i`=1, `operand_o` equals `imm8_i` zero-extended to 32 bits and rotated right by 2×`rot4_i` bit positions.
- R2: With `imm_mode_i`=1, `carry_o` equals `carry_i` when `rot4_i`=0, and otherwise equals bit 31 of `operand_o`.
- R3: With `imm_mode_i`=0, the shift amount is `rs_byte_i` (0..255) when `amt_from_reg_i`=1, and otherwise `amt_imm_i` zero-extended. The shift kind is encoded in `sh_kind_i` as 00 = logical left, 01 = logical right, 10 = arithmetic right, 11 = rotate right.
- R4: In register mode with a shift amount of 0, any kind leaves `rm_val_i` unchanged on `operand_o`, and `carry_o` equals `carry_i`.
- R5: A logical left shift by n in 1..31 gives `rm_val_i` << n, with carry equal to bit 32−n of `rm_val_i`.
- R6: A logical right shift by n in 1..31 gives `rm_val_i` >> n with zero fill, with carry equal to bit n−1 of `rm_val_i`.
- R7: An arithmetic right shift fills from bit 31. For n in 1..31 the carry is bit n−1. For n ≥ 32 every result bit and the carry equal bit 31.
- R8: A rotate right uses n mod 32. A nonzero n that is a multiple of 32 returns the value unchanged, with carry equal to bit 31. Otherwise the carry equals bit (n mod 32)−1 of the input.
- R9: A logical shift by exactly 32 gives 0. The carry is bit 0 for a left shift and bit 31 for a right shift.
- R10: A logical left or right shift by more than 32 gives 0 with carry 0.
- R11: In immediate mode, `rm_val_i`, `sh_kind_i`, `amt_from_reg_i`, `amt_imm_i` and `rs_byte_i` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_mode_i | input | 1 | 1 = rotated immediate, 0 = shifted register |
| imm8_i | input | 8 | Immediate constant |
| rot4_i | input | 4 | Rotate field; the rotation is twice this value |
| rm_val_i | input | 32 | Register value to be shifted |
| sh_kind_i | input | 2 | Shift kind (00 LSL, 01 LSR, 10 ASR, 11 ROR) |
| amt_from_reg_i | input | 1 | 1 = amount from `rs_byte_i`, 0 = from `amt_imm_i` |
| amt_imm_i | input | 5 | Shift amount encoded in the instruction |
| rs_byte_i | input | 8 | Low byte of the amount register |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Second ALU operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Both results are purely combinational, so each one is due in the same cycle in which its inputs are applied. The bench drives a new set of inputs just after a rising edge and samples `operand_o` and `carry_o` at the following falling edge. This leaves half a period for the logic to settle, and no result depends on the order of events at the edge. Expected values come from a model in the bench that uses double-width shifts. Register-mode amounts at 0, 1, 31, 32, 33, 64 and 255 are swept for every shift kind.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int SOP_DW = 32;  // operand width
    localparam int SOP_AW = 8;   // register-supplied amount width
    localparam int SOP_IW = 5;   // instruction-field amount width
    localparam int SOP_KW = 8;   // immediate constant width
    localparam int SOP_RW = 4;   // rotate field width

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } sh_kind_e;

    typedef struct packed {
        logic [SOP_DW-1:0] value;
        logic              carry;
    } sop_res_t;

    typedef struct packed {
        sh_kind_e          kind;
        logic [SOP_AW-1:0] amt;
        logic [SOP_DW-1:0] value;
        logic              cin;
    } sop_req_t;

    // Zero-extend an instruction-field amount to the register-amount width.
    function automatic logic [SOP_AW-1:0] widen_amt(input logic [SOP_IW-1:0] a);
        return {{(SOP_AW-SOP_IW){1'b0}}, a};
    endfunction

endpackage

// File: rtl/sop_rotr.sv
module sop_rotr #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = data_i;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int K = 1 << s;
        assign stage[s+1] = amt_i[s] ? ((stage[s] >> K) | (stage[s] << (W - K)))
                                     : stage[s];
    end

    assign data_o = stage[SW];
endmodule

// File: rtl/sop_imm_expand.sv
module sop_imm_expand
    import sop_pkg::*;
#(
    parameter int DW = SOP_DW,
    parameter int KW = SOP_KW,
    parameter int RW = SOP_RW,
    localparam int SW = $clog2(DW)
) (
    input  logic [KW-1:0] imm_i,
    input  logic [RW-1:0] rot_i,
    input  logic          cin_i,
    output sop_res_t      res_o
);
    logic [DW-1:0] widened;
    logic [SW-1:0] twice;
    logic [DW-1:0] rotated;

    assign widened = {{(DW-KW){1'b0}}, imm_i};
    assign twice   = SW'({rot_i, 1'b0});

    sop_rotr #(.W(DW)) u_rot (
        .data_i (widened),
        .amt_i  (twice),
        .data_o (rotated)
    );

    always_comb begin
        res_o.value = rotated;
        res_o.carry = (rot_i == '0) ? cin_i : rotated[DW-1];
    end
endmodule

// File: rtl/sop_amt_sel.sv
module sop_amt_sel
    import sop_pkg::*;
(
    input  logic              from_reg_i,
    input  logic [SOP_IW-1:0] field_i,
    input  logic [SOP_AW-1:0] reg_byte_i,
    output logic [SOP_AW-1:0] amt_o
);
    assign amt_o = from_reg_i ? reg_byte_i : widen_amt(field_i);
endmodule

// File: rtl/sop_shift_core.sv
module sop_shift_core
    import sop_pkg::*;
#(
    parameter int DW = SOP_DW,
    localparam int SW = $clog2(DW)
) (
    input  sop_req_t req_i,
    output sop_res_t res_o
);
    logic [DW-1:0] v;
    logic [SW-1:0] low;
    logic          in_range;   // amount below DW
    logic          exact;      // amount equal to DW
    logic [DW-1:0] ror_val;

    assign v        = req_i.value;
    assign low      = req_i.amt[SW-1:0];
    assign in_range = (req_i.amt < SOP_AW'(DW));
    assign exact    = (req_i.amt == SOP_AW'(DW));

    sop_rotr #(.W(DW)) u_ror (
        .data_i (v),
        .amt_i  (low),
        .data_o (ror_val)
    );

    always_comb begin
        res_o.value = v;
        res_o.carry = req_i.cin;
        if (req_i.amt != '0) begin
            unique case (req_i.kind)
                SK_LSL: begin
                    if (in_range) begin
                        res_o.value = v << low;
                        res_o.carry = v[DW - int'(low)];
                    end else begin
                        res_o.value = '0;
                        res_o.carry = exact ? v[0] : 1'b0;
                    end
                end
                SK_LSR: begin
                    if (in_range) begin
                        res_o.value = v >> low;
                        res_o.carry = v[int'(low) - 1];
                    end else begin
                        res_o.value = '0;
                        res_o.carry = exact ? v[DW-1] : 1'b0;
                    end
                end
                SK_ASR: begin
                    if (in_range) begin
                        res_o.value = DW'($signed(v) >>> low);
                        res_o.carry = v[int'(low) - 1];
                    end else begin
                        res_o.value = {DW{v[DW-1]}};
                        res_o.carry = v[DW-1];
                    end
                end
                SK_ROR: begin
                    res_o.value = ror_val;
                    res_o.carry = ror_val[DW-1];
                end
                default: begin
                    res_o.value = v;
                    res_o.carry = req_i.cin;
                end
            endcase
        end
    end
endmodule

// File: rtl/shift_operand_unit.sv
module shift_operand_unit
    import sop_pkg::*;
(
    input  logic              imm_mode_i,
    input  logic [SOP_KW-1:0] imm8_i,
    input  logic [SOP_RW-1:0] rot4_i,
    input  logic [SOP_DW-1:0] rm_val_i,
    input  logic [1:0]        sh_kind_i,
    input  logic              amt_from_reg_i,
    input  logic [SOP_IW-1:0] amt_imm_i,
    input  logic [SOP_AW-1:0] rs_byte_i,
    input  logic              carry_i,
    output logic [SOP_DW-1:0] operand_o,
    output logic              carry_o
);
    logic [SOP_AW-1:0] amt;
    sop_req_t          req;
    sop_res_t          imm_res;
    sop_res_t          reg_res;
    sop_res_t          sel_res;

    sop_amt_sel u_amt (
        .from_reg_i (amt_from_reg_i),
        .field_i    (amt_imm_i),
        .reg_byte_i (rs_byte_i),
        .amt_o      (amt)
    );

    always_comb begin
        req.kind  = sh_kind_e'(sh_kind_i);
        req.amt   = amt;
        req.value = rm_val_i;
        req.cin   = carry_i;
    end

    sop_shift_core u_core (
        .req_i (req),
        .res_o (reg_res)
    );

    sop_imm_expand u_imm (
        .imm_i (imm8_i),
        .rot_i (rot4_i),
        .cin_i (carry_i),
        .res_o (imm_res)
    );

    assign sel_res   = imm_mode_i ? imm_res : reg_res;
    assign operand_o = sel_res.value;
    assign carry_o   = sel_res.carry;
endmodule

// File: rtl/sop_checker.sv
module sop_checker
    import sop_pkg::*;
(
    input logic              imm_mode_i,
    input logic [SOP_KW-1:0] imm8_i,
    input logic [SOP_RW-1:0] rot4_i,
    input logic [SOP_DW-1:0] rm_val_i,
    input logic [1:0]        sh_kind_i,
    input logic              amt_from_reg_i,
    input logic [SOP_IW-1:0] amt_imm_i,
    input logic [SOP_AW-1:0] rs_byte_i,
    input logic              carry_i,
    input logic [SOP_DW-1:0] operand_o,
    input logic              carry_o
);
    logic [SOP_AW-1:0] eff;
    assign eff = amt_from_reg_i ? rs_byte_i : SOP_AW'(amt_imm_i);

    always_comb begin
        // R2: an unrotated immediate carries the flag through untouched
        if (imm_mode_i && rot4_i == '0)
            p_imm_norot_r2: assert (operand_o == SOP_DW'(imm8_i) && carry_o == carry_i);
        // R1: rotation neither adds nor drops set bits
        if (imm_mode_i)
            p_imm_bits_r1: assert ($countones(operand_o) == $countones(imm8_i));
        // R4: zero amount is a pass-through
        if (!imm_mode_i && eff == '0)
            p_zero_amt_r4: assert (operand_o == rm_val_i && carry_o == carry_i);
        // R10: oversized logical shifts clear everything
        if (!imm_mode_i && !sh_kind_i[1] && eff > 8'd32)
            p_big_logic_r10: assert (operand_o == '0 && !carry_o);
        // R7: oversized arithmetic shift replicates the sign
        if (!imm_mode_i && sh_kind_i == 2'b10 && eff >= 8'd32)
            p_asr_fill_r7: assert (operand_o == {SOP_DW{rm_val_i[SOP_DW-1]}}
                                   && carry_o == rm_val_i[SOP_DW-1]);
        // R8: rotation preserves population count
        if (!imm_mode_i && sh_kind_i == 2'b11)
            p_ror_bits_r8: assert ($countones(operand_o) == $countones(rm_val_i));
    end
endmodule

bind shift_operand_unit sop_checker u_sop_checker (
    .imm_mode_i     (imm_mode_i),
    .imm8_i         (imm8_i),
    .rot4_i         (rot4_i),
    .rm_val_i       (rm_val_i),
    .sh_kind_i      (sh_kind_i),
    .amt_from_reg_i (amt_from_reg_i),
    .amt_imm_i      (amt_imm_i),
    .rs_byte_i      (rs_byte_i),
    .carry_i        (carry_i),
    .operand_o      (operand_o),
    .carry_o        (carry_o)
);

// File: tb/shift_operand_unit_bench.sv
module shift_operand_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imm_mode = 1'b0;
    logic [7:0]  imm8 = '0;
    logic [3:0]  rot4 = '0;
    logic [31:0] rm_val = '0;
    logic [1:0]  sh_kind = '0;
    logic        from_reg = 1'b0;
    logic [4:0]  amt_imm = '0;
    logic [7:0]  rs_byte = '0;
    logic        cin = 1'b0;
    logic [31:0] operand;
    logic        cout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    shift_operand_unit u_shift_operand_unit (
        .imm_mode_i     (imm_mode),
        .imm8_i         (imm8),
        .rot4_i         (rot4),
        .rm_val_i       (rm_val),
        .sh_kind_i      (sh_kind),
        .amt_from_reg_i (from_reg),
        .amt_imm_i      (amt_imm),
        .rs_byte_i      (rs_byte),
        .carry_i        (cin),
        .operand_o      (operand),
        .carry_o        (cout)
    );

    // Reference for register mode, built from double-width shifts.
    task automatic model_reg(input logic [1:0] k, input int n, input logic [31:0] v,
                             input logic c, output logic [31:0] op, output logic co);
        logic [63:0]        w;
        logic signed [63:0] sw;
        int                 m;
        if (n == 0) begin
            op = v; co = c;
        end else if (k == 2'b00) begin
            w = {32'b0, v} << n; op = w[31:0]; co = w[32];
        end else if (k == 2'b01) begin
            w = {v, 32'b0} >> n; op = w[63:32]; co = w[31];
        end else if (k == 2'b10) begin
            sw = $signed({v, 32'b0}) >>> ((n > 63) ? 63 : n);
            op = sw[63:32]; co = sw[31];
        end else begin
            m = n % 32;
            if (m == 0) begin
                op = v; co = v[31];
            end else begin
                w = {v, v} >> m; op = w[31:0]; co = op[31];
            end
        end
    endtask

    task automatic model_imm(input logic [7:0] i, input logic [3:0] r, input logic c,
                             output logic [31:0] op, output logic co);
        logic [63:0] w;
        w  = {24'b0, i, 24'b0, i} >> (2 * r);
        op = w[31:0];
        co = (r == 0) ? c : op[31];
    endtask

    task automatic check(input string req, input logic [31:0] eop, input logic ec);
        n_checks++;
        if (operand !== eop || cout !== ec) begin
            n_fail++;
            $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
                     req, operand, cout, eop, ec);
        end
    endtask

    task automatic run_reg(input string req, input logic [1:0] k, input logic fr,
                           input int n, input logic [31:0] v, input logic c);
        logic [31:0] eop;
        logic        ec;
        @(posedge clk);
        imm_mode = 1'b0; sh_kind = k; from_reg = fr; rm_val = v; cin = c;
        if (fr) begin rs_byte = 8'(n); amt_imm = 5'd17; end
        else    begin amt_imm = 5'(n); rs_byte = 8'd200; end
        model_reg(k, n, v, c, eop, ec);
        @(negedge clk);
        check(req, eop, ec);
    endtask

    task automatic run_imm(input string req, input logic [7:0] i, input logic [3:0] r,
                           input logic c);
        logic [31:0] eop;
        logic        ec;
        @(posedge clk);
        imm_mode = 1'b1; imm8 = i; rot4 = r; cin = c;
        model_imm(i, r, c, eop, ec);
        @(negedge clk);
        check(req, eop, ec);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R4 idle state", 32'h0, 1'b0);
    endtask

    task automatic t_immediate();
        run_imm("R1 rot0", 8'hFF, 4'd0, 1'b1);
        run_imm("R1 ror8", 8'hFF, 4'd4, 1'b0);
        run_imm("R1 ror2", 8'h01, 4'd1, 1'b1);
        run_imm("R1 ror30", 8'h02, 4'd15, 1'b1);
        run_imm("R2 carry rot0 cin0", 8'h80, 4'd0, 1'b0);
        run_imm("R2 carry from bit31", 8'h03, 4'd1, 1'b0);
        run_imm("R2 carry clear", 8'h0C, 4'd1, 1'b1);
    endtask

    task automatic t_imm_ignores();
        logic [31:0] eop;
        logic        ec;
        model_imm(8'hA5, 4'd3, 1'b1, eop, ec);
        for (int j = 0; j < 4; j++) begin
            @(posedge clk);
            imm_mode = 1'b1; imm8 = 8'hA5; rot4 = 4'd3; cin = 1'b1;
            rm_val = 32'h1234_5678 * (j + 1); sh_kind = 2'(j);
            from_reg = j[0]; amt_imm = 5'(7 * j); rs_byte = 8'(60 * j);
            @(negedge clk);
            check("R11 register inputs ignored", eop, ec);
        end
    endtask

    task automatic t_amount_source();
        run_reg("R3 field amount", 2'b01, 1'b0, 4, 32'h8000_0000, 1'b0);
        run_reg("R3 register amount", 2'b01, 1'b1, 8, 32'h8000_0000, 1'b0);
        run_reg("R3 kind LSL code", 2'b00, 1'b1, 4, 32'h0000_00F1, 1'b0);
        run_reg("R3 kind ROR code", 2'b11, 1'b0, 4, 32'h0000_00F1, 1'b0);
    endtask

    task automatic t_zero_amount();
        for (int k = 0; k < 4; k++) begin
            run_reg("R4 zero field", 2'(k), 1'b0, 0, 32'h8765_4321, 1'b1);
            run_reg("R4 zero reg", 2'(k), 1'b1, 0, 32'h0F0F_0001, 1'b0);
        end
    endtask

    task automatic t_in_range();
        int amts [4] = '{1, 5, 16, 31};
        foreach (amts[a]) begin
            run_reg("R5 lsl", 2'b00, a[0], amts[a], 32'hC000_0003, 1'b0);
            run_reg("R6 lsr", 2'b01, a[0], amts[a], 32'hC000_0003, 1'b0);
            run_reg("R7 asr neg", 2'b10, a[0], amts[a], 32'h8000_0011, 1'b0);
            run_reg("R7 asr pos", 2'b10, a[0], amts[a], 32'h4000_0011, 1'b1);
            run_reg("R8 ror", 2'b11, a[0], amts[a], 32'h8000_0011, 1'b0);
        end
    endtask

    task automatic t_large();
        int amts [5] = '{32, 33, 64, 100, 255};
        foreach (amts[a]) begin
            run_reg("R9 R10 lsl big", 2'b00, 1'b1, amts[a], 32'hFFFF_FFFF, 1'b0);
            run_reg("R9 R10 lsr big", 2'b01, 1'b1, amts[a], 32'hFFFF_FFFF, 1'b0);
            run_reg("R7 asr big neg", 2'b10, 1'b1, amts[a], 32'h8000_0000, 1'b0);
            run_reg("R7 asr big pos", 2'b10, 1'b1, amts[a], 32'h7FFF_FFFF, 1'b1);
            run_reg("R8 ror big", 2'b11, 1'b1, amts[a], 32'h8000_0002, 1'b0);
        end
        run_reg("R9 lsl 32 bit0 clear", 2'b00, 1'b1, 32, 32'hFFFF_FFFE, 1'b1);
        run_reg("R9 lsr 32 bit31 clear", 2'b01, 1'b1, 32, 32'h7FFF_FFFF, 1'b1);
        run_reg("R8 ror 64 bit31 clear", 2'b11, 1'b1, 64, 32'h7000_0001, 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_immediate();
        t_imm_ignores();
        t_amount_source();
        t_zero_amount();
        t_in_range();
        t_large();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule